// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects events from a network controller in a 32-bit event register. Only the thirteen top bits (31 down to 19) hold events. A 32-bit mask register decides which of those events reach the processor. The block drives thirteen separate level interrupt lines, and each line follows one event bit ANDed with the mask bit at the same position.

Other logic in the controller raises events with one-cycle set strobes. Software writes the event register to clear bits: every 1 in the written word clears that bit. A write to the mask register replaces its whole value. Software can read both registers back.

Two writes elsewhere in the register map also raise events in this block, in the same cycle as the write:
- a write to the management-frame register raises the MII event;
- a write to the transmit-control register with bit 0 set raises the graceful-stop event.

The block decodes no addresses of its own. The surrounding decoder supplies one write strobe per register, and all writes share a single data bus. No data stream flows through the block, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `evirq_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`) clears the event register, the mask register and all thirteen interrupt lines to zero.
- R2: A 1 on bit b of `evt_set_i`, for b in 19..31, sets event bit b at the next clock edge. Other event bits are left as they were.
- R3: When `evt_wr_i` is high, every event bit whose `wdata_i` bit is 1 is cleared at the next edge. Every event bit whose `wdata_i` bit is 0 keeps its value.
- R4: When `mask_wr_i` is high, the mask register takes all 32 bits of `wdata_i` at the next edge. `mask_rd_o` shows the stored value.
- R5: Interrupt lines are registered. Each line equals (event bit AND mask bit) as it was in the previous cycle, so a line changes one clock after the event or mask change that drives it.
- R6: The line-to-event order is fixed, with the event bit position given in brackets:

  | Line | Event | Bit |
  |---|---|---|
  | 0 | transmit frame | 27 |
  | 1 | transmit buffer | 26 |
  | 2 | underrun | 19 |
  | 3 | retry limit | 20 |
  | 4 | receive frame | 25 |
  | 5 | receive buffer | 24 |
  | 6 | MII | 23 |
  | 7 | late collision | 21 |
  | 8 | heartbeat | 31 |
  | 9 | graceful stop | 28 |
  | 10 | bus error | 22 |
  | 11 | babbling transmit | 29 |
  | 12 | babbling receive | 30 |

- R7: Any cycle with `mgmt_wr_i` high sets event bit 23 (MII) at the next edge.
- R8: A cycle with `tctl_wr_i` high and `wdata_i[0]` = 1 sets event bit 28 (graceful stop) at the next edge. With `wdata_i[0]` = 0, the write leaves the event register unchanged.
- R9: If a set (from a strobe or a side-effect write) and a software clear hit the same event bit in the same cycle, the bit ends up set.
- R10: Event bits 18..0 always read as zero. Set strobes and writes cannot change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | 32 | Per-bit one-cycle event set strobes from controller logic |
| evt_wr_i | input | 1 | Write strobe for the event register (write-one-to-clear) |
| mask_wr_i | input | 1 | Write strobe for the mask register |
| mgmt_wr_i | input | 1 | Write strobe for the management-frame register (raises MII event) |
| tctl_wr_i | input | 1 | Write strobe for the transmit-control register |
| wdata_i | input | 32 | Shared write data for all write strobes |
| evt_rd_o | output | 32 | Event register readback |
| mask_rd_o | output | 32 | Mask register readback |
| irq_o | output | 13 | Level interrupt lines in the fixed order of R6 |

## Verification
The bench sets an event and clears the same bit in the same cycle. A design where the clear wins would show the bit as 0 after a MII or graceful-stop side effect.

It drives set strobes on bits 18..0 and expects them to stay zero. A design that failed to block those bits would show them in the readback.

It walks a single enabled event through each line in turn. This catches a swapped line order, and a line that changes on the same edge as its event instead of one cycle later.

Random mixes of strobes, partial clears and mask writes are checked against a reference model. A design that cleared bits written as 0, or merged the mask instead of replacing it, would disagree with the model.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
  localparam int unsigned EVT_W     = 32;
  localparam int unsigned LINES     = 13;
  localparam int unsigned LOW_DEAD  = EVT_W - LINES;   // bits 18..0 unused
  localparam int unsigned BIT_MII   = 23;
  localparam int unsigned BIT_GSTOP = 28;

  // Event bit that drives interrupt line idx.
  function automatic int unsigned line_src(input int unsigned idx);
    case (idx)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/evirq_set_merge.sv
module evirq_set_merge #(
  parameter int unsigned W       = evirq_pkg::EVT_W,
  parameter int unsigned MII_POS = evirq_pkg::BIT_MII,
  parameter int unsigned GS_POS  = evirq_pkg::BIT_GSTOP
) (
  input  logic [W-1:0] hw_set_i,
  input  logic         mgmt_wr_i,
  input  logic         tctl_wr_i,
  input  logic         tctl_go_i,
  output logic [W-1:0] set_o
);
  always_comb begin
    set_o = hw_set_i;
    if (mgmt_wr_i)              set_o[MII_POS] = 1'b1;
    if (tctl_wr_i && tctl_go_i) set_o[GS_POS]  = 1'b1;
  end
endmodule

// File: rtl/evirq_evt_reg.sv
module evirq_evt_reg #(
  parameter int unsigned W    = evirq_pkg::EVT_W,
  parameter int unsigned DEAD = evirq_pkg::LOW_DEAD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] evt_o
);
  localparam logic [W-1:0] LIVE = {{(W-DEAD){1'b1}}, {DEAD{1'b0}}};

  logic [W-1:0] evt_q;
  logic [W-1:0] clr_vec;

  assign clr_vec = clr_wr_i ? clr_data_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= ((evt_q & ~clr_vec) | set_i) & LIVE;
  end

  assign evt_o = evt_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_i & LIVE) |=> ((evt_q & $past(set_i & LIVE)) == $past(set_i & LIVE))); // R2
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((evt_q & $past(clr_data_i & ~set_i)) == '0)); // R3
  AST_KEEP_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & $past(evt_q & ~clr_vec)) == $past(evt_q & ~clr_vec))); // R3
endmodule

// File: rtl/evirq_mask_reg.sv
module evirq_mask_reg #(
  parameter int unsigned W = evirq_pkg::EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (mask_q == $past(wdata_i))); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(mask_q)); // R4
endmodule

// File: rtl/evirq_line_map.sv
module evirq_line_map #(
  parameter int unsigned W     = evirq_pkg::EVT_W,
  parameter int unsigned LINES = evirq_pkg::LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     evt_i,
  input  logic [W-1:0]     mask_i,
  output logic [LINES-1:0] irq_o
);
  logic [W-1:0]     live;
  logic [LINES-1:0] irq_d;
  logic [LINES-1:0] irq_q;

  assign live = evt_i & mask_i;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam int unsigned SRC = evirq_pkg::line_src(g);
    assign irq_d[g] = live[SRC];

    AST_LINE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q[g] == $past(evt_i[SRC] && mask_i[SRC]))); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_NO_MASKED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> (irq_q == '0)); // R5
endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl #(
  parameter int unsigned W     = evirq_pkg::EVT_W,
  parameter int unsigned LINES = evirq_pkg::LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     evt_set_i,
  input  logic             evt_wr_i,
  input  logic             mask_wr_i,
  input  logic             mgmt_wr_i,
  input  logic             tctl_wr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     evt_rd_o,
  output logic [W-1:0]     mask_rd_o,
  output logic [LINES-1:0] irq_o
);
  localparam int unsigned DEAD = W - LINES;

  logic [W-1:0] set_all;
  logic [W-1:0] evt_q;
  logic [W-1:0] mask_q;

  evirq_set_merge #(.W(W)) u_merge (
    .hw_set_i  (evt_set_i),
    .mgmt_wr_i (mgmt_wr_i),
    .tctl_wr_i (tctl_wr_i),
    .tctl_go_i (wdata_i[0]),
    .set_o     (set_all)
  );

  evirq_evt_reg #(.W(W), .DEAD(DEAD)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (set_all),
    .clr_wr_i   (evt_wr_i),
    .clr_data_i (wdata_i),
    .evt_o      (evt_q)
  );

  evirq_mask_reg #(.W(W)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (mask_wr_i),
    .wdata_i (wdata_i),
    .mask_o  (mask_q)
  );

  evirq_line_map #(.W(W), .LINES(LINES)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_q),
    .mask_i (mask_q),
    .irq_o  (irq_o)
  );

  assign evt_rd_o  = evt_q;
  assign mask_rd_o = mask_q;

  AST_MII_ON_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_wr_i |=> evt_rd_o[evirq_pkg::BIT_MII]); // R7 R9
  AST_GSTOP_ON_TCTL: assert property (@(posedge clk) disable iff (!rst_n)
    (tctl_wr_i && wdata_i[0]) |=> evt_rd_o[evirq_pkg::BIT_GSTOP]); // R8 R9
  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_o[DEAD-1:0] == '0); // R10
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (evt_rd_o == '0 && mask_rd_o == '0 && irq_o == '0)); // R1
endmodule

// File: tb/evirq_ctrl_test.sv
module evirq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_set_i = '0;
  logic        evt_wr_i = 1'b0;
  logic        mask_wr_i = 1'b0;
  logic        mgmt_wr_i = 1'b0;
  logic        tctl_wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] evt_rd_o;
  logic [31:0] mask_rd_o;
  logic [12:0] irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;
  logic [12:0] m_irq = '0;

  always #5 clk = ~clk;

  evirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_set_i(evt_set_i), .evt_wr_i(evt_wr_i),
    .mask_wr_i(mask_wr_i), .mgmt_wr_i(mgmt_wr_i), .tctl_wr_i(tctl_wr_i),
    .wdata_i(wdata_i), .evt_rd_o(evt_rd_o), .mask_rd_o(mask_rd_o), .irq_o(irq_o)
  );

  // Event bit for each line, as listed in R6.
  function automatic int unsigned src_of(input int unsigned k);
    int unsigned t [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return t[k];
  endfunction

  function automatic logic [12:0] lines_of(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r;
    for (int k = 0; k < 13; k++) r[k] = e[src_of(k)] & m[src_of(k)];
    return r;
  endfunction

  function automatic logic [31:0] next_evt(input logic [31:0] e);
    logic [31:0] s;
    logic [31:0] c;
    s = evt_set_i;
    if (mgmt_wr_i) s[23] = 1'b1;
    if (tctl_wr_i && wdata_i[0]) s[28] = 1'b1;
    c = evt_wr_i ? wdata_i : 32'h0;
    return ((e & ~c) | s) & 32'hFFF8_0000;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Apply current inputs for one edge, update model, compare all outputs.
  task automatic step(input string tag);
    logic [31:0] ne;
    logic [31:0] nm;
    ne = next_evt(m_evt);
    nm = mask_wr_i ? wdata_i : m_mask;
    @(posedge clk);
    m_irq  = lines_of(m_evt, m_mask);
    m_evt  = ne;
    m_mask = nm;
    #1;
    check(tag, "evt", evt_rd_o, m_evt);
    check(tag, "mask", mask_rd_o, m_mask);
    check(tag, "irq", {19'h0, irq_o}, {19'h0, m_irq});
    @(negedge clk);
    evt_set_i = '0; evt_wr_i = 0; mask_wr_i = 0; mgmt_wr_i = 0; tctl_wr_i = 0; wdata_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1", "evt", evt_rd_o, 32'h0);
    check("R1", "mask", mask_rd_o, 32'h0);
    check("R1", "irq", {19'h0, irq_o}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    m_evt = '0; m_mask = '0; m_irq = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    do_reset();

    // R10: set strobes on dead bits have no effect
    evt_set_i = 32'h0007_FFFF; step("R10");
    // R2: set every live bit
    evt_set_i = 32'hFFF8_0000; step("R2");
    // R3: partial clear, other bits kept
    evt_wr_i = 1; wdata_i = 32'hA5A0_0000; step("R3");
    // R4: mask replace, then replace again with fewer bits
    mask_wr_i = 1; wdata_i = 32'hFFFF_FFFF; step("R4");
    mask_wr_i = 1; wdata_i = 32'h1234_5678; step("R4");
    step("R5");
    // clear all, then R6 walk: single event/mask per line
    evt_wr_i = 1; wdata_i = 32'hFFFF_FFFF; step("R3");
    mask_wr_i = 1; wdata_i = 32'hFFFF_FFFF; step("R4");
    for (int k = 0; k < 13; k++) begin
      evt_set_i = 32'h1 << src_of(k); step("R6");
      step("R6");
      check("R6", "line", {19'h0, irq_o}, {19'h0, 13'h1 << k});
      evt_wr_i = 1; wdata_i = 32'h1 << src_of(k); step("R6");
      step("R5");
    end
    // R7: management write
    mgmt_wr_i = 1; wdata_i = 32'h0; step("R7");
    // R8: transmit control with bit0 low then high
    evt_wr_i = 1; wdata_i = 32'hFFFF_FFFF; step("R3");
    tctl_wr_i = 1; wdata_i = 32'hFFFF_FFFE; step("R8");
    tctl_wr_i = 1; wdata_i = 32'h1; step("R8");
    // R9: set and clear collide
    evt_wr_i = 1; mgmt_wr_i = 1; wdata_i = 32'hFFFF_FFFF; step("R9");
    check("R9", "mii bit", {31'h0, evt_rd_o[23]}, 32'h1);
    evt_wr_i = 1; tctl_wr_i = 1; wdata_i = 32'hFFFF_FFFF; step("R9");
    check("R9", "gstop bit", {31'h0, evt_rd_o[28]}, 32'h1);
    evt_wr_i = 1; evt_set_i = 32'h8000_0000; wdata_i = 32'h8000_0000; step("R9");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      r = $urandom();
      evt_set_i = ($urandom() & $urandom());
      evt_wr_i  = r[0];
      mask_wr_i = r[1] & r[2];
      mgmt_wr_i = r[3] & r[4];
      tctl_wr_i = r[5] & r[6];
      wdata_i   = $urandom();
      step("R2 R3 R4 R5");
    end

    // R1 again after activity
    do_reset();
    step("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule